// File: doc/BRIEF.md
# USB Endpoint OUT Packet FIFO

This block is the receive buffer of one USB device OUT endpoint. The packet engine on the bus side pushes bytes one at a time. It closes each packet with either a good strobe or a bad strobe. Only a packet closed as good becomes visible to the consumer. The consumer is a CPU or DMA engine. It sees a ready flag and the byte length of the oldest stored packet, reads bytes in order, and then gives the packet back. It can give the packet back with a clear command, with a serviced command in control-endpoint mode, by reading a full maximum-size packet when auto-clear is on, or with a flush.

Storage is one circular byte array. The configured maximum packet size decides how many packets the array may hold. A size of at most half the array allows two packets, so a second packet can arrive while the first is being unloaded. A larger size allows only one packet. When no packet slot is free, the block shows a full indication so that the bus side can answer NAK. Any packet that starts while this indication is up is discarded as a whole, even if a slot frees before the packet ends.

Top module: `usb_out_pkt_fifo`

## Requirements
- R1: After reset `pkt_rdy` is 0, `rx_full` is 0 and `pkt_len` is 0.
- R2: A packet closed by `rx_good` raises `pkt_rdy` on the next clock edge. `pkt_len` then equals its byte count. `rd_data` shows its bytes in arrival order, and each `rd_en` accepted while `pkt_rdy` is 1 moves to the next byte.
- R3: A packet closed by `rx_bad` never raises `pkt_rdy`. A later good packet holds only its own bytes.
- R4: When `cfg_maxp` is at most DEPTH/2, two packets are held. `rx_full` rises only after the second one. Releasing the oldest keeps `pkt_rdy` at 1 and presents the second packet's length and data.
- R5: When `cfg_maxp` exceeds DEPTH/2, one packet is held and `rx_full` is 1 while it is stored. A packet that starts while `rx_full` is 1 is dropped entirely, even if a slot frees before it ends.
- R6: In data mode (`cfg_ctrl_ep`=0) a `clr_rdy` pulse releases the oldest packet, and `serviced` has no effect.
- R7: In control mode (`cfg_ctrl_ep`=1) a `serviced` pulse releases the oldest packet. `clr_rdy` has no effect and auto-clear is inactive.
- R8: In data mode with `cfg_auto_clr`=1, the read that consumes byte number `cfg_maxp` releases the packet at that same edge. A shorter packet is not released by reading, even with extra `rd_en` pulses beyond its length.
- R9: A `flush` pulse releases the oldest packet in any mode. With two stored, the newer one stays ready.
- R10: `rd_en` while `pkt_rdy` is 0 has no effect. The next packet is read from its first byte.
- R11: Bytes beyond `cfg_maxp` in one packet are discarded, so the stored length is at most `cfg_maxp`.
- R12: A release and an `rx_good` in the same cycle both take effect. With one packet stored, `pkt_rdy` stays 1 and the new packet becomes the oldest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_maxp | input | CW | Maximum packet size in bytes (clamped to DEPTH) |
| cfg_auto_clr | input | 1 | Release by reading a full maximum-size packet |
| cfg_ctrl_ep | input | 1 | Control-endpoint mode: release by `serviced` |
| rx_valid | input | 1 | Byte strobe from the packet engine |
| rx_data | input | DW | Received byte |
| rx_good | input | 1 | Packet ended without error |
| rx_bad | input | 1 | Packet ended with error |
| rx_full | output | 1 | No free packet slot (NAK) |
| rd_en | input | 1 | Consume the presented byte |
| rd_data | output | DW | Byte at the read position of the oldest packet |
| pkt_rdy | output | 1 | A complete packet is available |
| pkt_len | output | CW | Byte count of the oldest packet |
| clr_rdy | input | 1 | Data-mode clear of the ready flag |
| serviced | input | 1 | Control-mode clear of the ready flag |
| flush | input | 1 | Discard the oldest packet |

## Verification
Two functions can fall in the same cycle: the end of a new packet (`rx_good`) and the release of the stored packet (clear, serviced, flush or the read that triggers auto-clear). The bench forces this overlap on purpose by pulsing `clr_rdy` in the same cycle as `rx_good` while one packet is held in two-packet mode. Random runs also produce the overlap. The result counts as correct only if the ready flag stays up without a gap, `pkt_len` switches to the new packet's count, and its bytes read back unchanged against the bench's packet model.

// File: rtl/usb_out_pkt_fifo_pkg.sv
package usb_out_pkt_fifo_pkg;
   typedef enum logic [1:0] {
      LQ_HOLD = 2'd0,
      LQ_PUSH = 2'd1,
      LQ_POP  = 2'd2,
      LQ_BOTH = 2'd3
   } lq_op_e;
endpackage

// File: rtl/uof_byte_ram.sv
module uof_byte_ram #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/uof_rx_writer.sv
module uof_rx_writer #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] eff_maxp,
   input  logic          slot_free,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_good,
   input  logic          rx_bad,
   output logic          mem_we,
   output logic [AW-1:0] mem_waddr,
   output logic [DW-1:0] mem_wdata,
   output logic          push,
   output logic [CW-1:0] push_len
);
   logic [AW-1:0] wr_ptr, wr_base;
   logic [CW-1:0] wcnt;
   logic          drop_q;
   logic          blocked, end_evt, byte_ok;

   // a packet is refused for its whole life if it opened with no slot
   assign blocked  = drop_q || ((wcnt == '0) && !slot_free);
   assign end_evt  = rx_good || rx_bad;
   assign byte_ok  = rx_valid && !end_evt && !blocked;
   assign mem_we   = byte_ok && (wcnt < eff_maxp);
   assign mem_waddr = wr_ptr;
   assign mem_wdata = rx_data;
   assign push     = rx_good && !rx_bad && !blocked;
   assign push_len = wcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         wr_base <= '0;
         wcnt    <= '0;
         drop_q  <= 1'b0;
      end else if (end_evt) begin
         drop_q <= 1'b0;
         wcnt   <= '0;
         if (!blocked) begin
            if (rx_bad) wr_ptr  <= wr_base;
            else        wr_base <= wr_ptr;
         end
      end else if (rx_valid && blocked) begin
         drop_q <= 1'b1;
      end else if (mem_we) begin
         wr_ptr <= wr_ptr + 1'b1;
         wcnt   <= wcnt + 1'b1;
      end
   end
endmodule

// File: rtl/uof_len_queue.sv
module uof_len_queue
   import usb_out_pkt_fifo_pkg::*;
#(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [CW-1:0] push_len,
   input  logic          pop,
   output logic [1:0]    count,
   output logic [CW-1:0] head_len
);
   logic [CW-1:0] len_q [2];
   logic          pop_ok;
   lq_op_e        op;

   assign pop_ok   = pop && (count != 2'd0);
   assign op       = lq_op_e'({pop_ok, push});
   assign head_len = len_q[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= 2'd0;
         len_q[0] <= '0;
         len_q[1] <= '0;
      end else begin
         unique case (op)
            LQ_PUSH: begin
               if (count == 2'd0) len_q[0] <= push_len;
               else               len_q[1] <= push_len;
               count <= count + 2'd1;
            end
            LQ_POP: begin
               len_q[0] <= len_q[1];
               count    <= count - 2'd1;
            end
            LQ_BOTH: begin
               if (count == 2'd1) begin
                  len_q[0] <= push_len;
               end else begin
                  len_q[0] <= len_q[1];
                  len_q[1] <= push_len;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/uof_rd_ctrl.sv
module uof_rd_ctrl #(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          head_valid,
   input  logic [CW-1:0] head_len,
   input  logic [CW-1:0] eff_maxp,
   input  logic          auto_en,
   input  logic          ctrl_mode,
   input  logic          rd_en,
   input  logic          clr_rdy,
   input  logic          serviced,
   input  logic          flush,
   output logic [AW-1:0] raddr,
   output logic [CW-1:0] rd_cnt,
   output logic          pop
);
   logic [AW-1:0] rd_base;
   logic          rd_ok, auto_hit, cmd;

   assign rd_ok    = rd_en && head_valid && (rd_cnt < head_len);
   assign auto_hit = auto_en && !ctrl_mode && rd_ok && ((rd_cnt + 1'b1) == eff_maxp);
   assign cmd      = ctrl_mode ? serviced : clr_rdy;
   assign pop      = head_valid && (flush || cmd || auto_hit);
   assign raddr    = rd_base + rd_cnt[AW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_base <= '0;
         rd_cnt  <= '0;
      end else if (pop) begin
         rd_base <= rd_base + head_len[AW-1:0];
         rd_cnt  <= '0;
      end else if (rd_ok) begin
         rd_cnt <= rd_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/usb_out_pkt_fifo.sv
module usb_out_pkt_fifo #(
   parameter int DEPTH         = 64,
   parameter int DW            = 8,
   parameter bit DOUBLE_BUF_EN = 1'b1,
   localparam int AW           = $clog2(DEPTH),
   localparam int CW           = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cfg_maxp,
   input  logic          cfg_auto_clr,
   input  logic          cfg_ctrl_ep,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_good,
   input  logic          rx_bad,
   output logic          rx_full,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          pkt_rdy,
   output logic [CW-1:0] pkt_len,
   input  logic          clr_rdy,
   input  logic          serviced,
   input  logic          flush
);
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 4");
   end
   if (DW < 1) begin : g_bad_dw
      $error("DW must be at least 1");
   end

   logic [CW-1:0] eff_maxp;
   logic          cap_two, slot_free;
   logic          mem_we, push, pop;
   logic [AW-1:0] mem_waddr, raddr;
   logic [DW-1:0] mem_wdata;
   logic [CW-1:0] push_len, rd_cnt;
   logic [1:0]    q_count;

   assign eff_maxp = (cfg_maxp > CW'(DEPTH)) ? CW'(DEPTH) : cfg_maxp;

   if (DOUBLE_BUF_EN) begin : g_dbl
      assign cap_two = (eff_maxp <= CW'(DEPTH / 2));
   end else begin : g_sgl
      assign cap_two = 1'b0;
   end

   assign slot_free = (q_count == 2'd0) || (cap_two && (q_count == 2'd1));
   assign rx_full   = !slot_free;
   assign pkt_rdy   = (q_count != 2'd0);

   uof_rx_writer #(.DEPTH(DEPTH), .DW(DW)) u_wr (
      .clk, .rst_n, .eff_maxp, .slot_free,
      .rx_valid, .rx_data, .rx_good, .rx_bad,
      .mem_we, .mem_waddr, .mem_wdata, .push, .push_len
   );

   uof_byte_ram #(.DEPTH(DEPTH), .DW(DW)) u_ram (
      .clk, .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr, .rdata(rd_data)
   );

   uof_len_queue #(.CW(CW)) u_lq (
      .clk, .rst_n, .push, .push_len, .pop,
      .count(q_count), .head_len(pkt_len)
   );

   uof_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
      .clk, .rst_n, .head_valid(pkt_rdy), .head_len(pkt_len), .eff_maxp,
      .auto_en(cfg_auto_clr), .ctrl_mode(cfg_ctrl_ep),
      .rd_en, .clr_rdy, .serviced, .flush,
      .raddr, .rd_cnt, .pop
   );
endmodule

// File: rtl/uof_chk.sv
module uof_chk #(
   parameter int CW = 7
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pkt_rdy,
   input logic          rx_full,
   input logic [CW-1:0] pkt_len,
   input logic [CW-1:0] eff_maxp,
   input logic [1:0]    q_count,
   input logic          cap_two,
   input logic [CW-1:0] rd_cnt,
   input logic          rx_bad,
   input logic          cfg_ctrl_ep,
   input logic          serviced,
   input logic          flush
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!pkt_rdy && !rx_full));

   // R4
   slot_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= (cap_two ? 2'd2 : 2'd1));

   // R11
   len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_rdy |-> (pkt_len <= eff_maxp));

   // R10
   idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pkt_rdy |-> (rd_cnt == '0));

   // R7
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_rdy && cfg_ctrl_ep && !serviced && !flush) |=> pkt_rdy);

   // R3
   bad_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_bad |=> !$rose(pkt_rdy));
endmodule

bind usb_out_pkt_fifo uof_chk #(.CW(CW)) u_chk (
   .clk, .rst_n, .pkt_rdy, .rx_full, .pkt_len, .eff_maxp, .q_count,
   .cap_two, .rd_cnt, .rx_bad, .cfg_ctrl_ep, .serviced, .flush
);

// File: tb/usb_out_pkt_fifo_tb_top.sv
module usb_out_pkt_fifo_tb_top;
   localparam int DEPTH = 64;
   localparam int DW    = 8;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] cfg_maxp = '0;
   logic          cfg_auto_clr = 1'b0, cfg_ctrl_ep = 1'b0;
   logic          rx_valid = 1'b0, rx_good = 1'b0, rx_bad = 1'b0;
   logic [DW-1:0] rx_data = '0;
   logic          rd_en = 1'b0, clr_rdy = 1'b0, serviced = 1'b0, flush = 1'b0;
   logic          rx_full, pkt_rdy;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] pkt_len;

   always #10 clk = ~clk;

   usb_out_pkt_fifo #(.DEPTH(DEPTH), .DW(DW), .DOUBLE_BUF_EN(1'b1)) dut_i (
      .clk, .rst_n, .cfg_maxp, .cfg_auto_clr, .cfg_ctrl_ep,
      .rx_valid, .rx_data, .rx_good, .rx_bad, .rx_full,
      .rd_en, .rd_data, .pkt_rdy, .pkt_len, .clr_rdy, .serviced, .flush
   );

   int n_chk = 0, n_fail = 0;
   int mmaxp = 0, mcap = 1, mcount = 0, mrd = 0;
   bit mauto = 0, mctrl = 0;
   int mlen [2];
   logic [DW-1:0] mdat [2][DEPTH];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   function automatic void m_pop();
      if (mcount > 0) begin
         mlen[0] = mlen[1];
         for (int i = 0; i < DEPTH; i++) mdat[0][i] = mdat[1][i];
         mcount--;
         mrd = 0;
      end
   endfunction

   task automatic check_state(input string tag);
      chk(pkt_rdy == (mcount != 0), {tag, " pkt_rdy"}, int'(pkt_rdy), int'(mcount != 0));
      chk(rx_full == (mcount >= mcap), {tag, " rx_full"}, int'(rx_full), int'(mcount >= mcap));
      if (mcount > 0)
         chk(int'(pkt_len) == mlen[0], {tag, " pkt_len"}, int'(pkt_len), mlen[0]);
   endtask

   // sends len bytes then an end strobe; with_clr pulses clr_rdy in the end cycle
   task automatic send_pkt(input int len, input bit good, input bit with_clr);
      logic [DW-1:0] tmp [DEPTH + 8];
      bit blocked;
      int stored;
      blocked = (mcount >= mcap);
      for (int i = 0; i < len; i++) begin
         tmp[i] = DW'($urandom);
         rx_valid = 1'b1;
         rx_data  = tmp[i];
         @(negedge clk);
      end
      rx_valid = 1'b0;
      rx_good  = good;
      rx_bad   = !good;
      clr_rdy  = with_clr;
      @(negedge clk);
      rx_good = 1'b0; rx_bad = 1'b0; clr_rdy = 1'b0;
      if (with_clr && !mctrl) m_pop();
      if (good && !blocked) begin
         stored = (len < mmaxp) ? len : mmaxp;
         mlen[mcount] = stored;
         for (int i = 0; i < stored; i++) mdat[mcount][i] = tmp[i];
         mcount++;
      end
   endtask

   task automatic read_n(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         if (mcount > 0 && mrd < mlen[0])
            chk(rd_data == mdat[0][mrd], {tag, " rd_data"}, int'(rd_data), int'(mdat[0][mrd]));
         rd_en = 1'b1;
         @(negedge clk);
         rd_en = 1'b0;
         if (mcount > 0 && mrd < mlen[0]) begin
            mrd++;
            if (mauto && !mctrl && mrd == mmaxp) m_pop();
         end
      end
   endtask

   task automatic pulse(input bit c, input bit s, input bit f);
      clr_rdy = c; serviced = s; flush = f;
      @(negedge clk);
      clr_rdy = 1'b0; serviced = 1'b0; flush = 1'b0;
      if (f || (mctrl ? s : c)) m_pop();
   endtask

   task automatic set_cfg(input int maxp, input bit au, input bit ct);
      while (mcount > 0) pulse(1'b0, 1'b0, 1'b1);
      cfg_maxp = CW'(maxp); cfg_auto_clr = au; cfg_ctrl_ep = ct;
      mmaxp = maxp; mauto = au; mctrl = ct;
      mcap = (maxp <= DEPTH / 2) ? 2 : 1;
      @(negedge clk);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_state("R1 in reset");
      chk(pkt_len == '0, "R1 pkt_len", int'(pkt_len), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset");

      // R2 basic packet, double mode, manual clear
      set_cfg(16, 1'b0, 1'b0);
      send_pkt(5, 1'b1, 1'b0);
      check_state("R2 good packet");
      read_n(5, "R2");
      pulse(1'b1, 1'b0, 1'b0);
      check_state("R6 clear");

      // R10 reads while empty are ignored
      read_n(3, "R10");
      send_pkt(4, 1'b1, 1'b0);
      read_n(4, "R10 first byte");
      pulse(1'b1, 1'b0, 1'b0);

      // R3 bad packet
      send_pkt(6, 1'b0, 1'b0);
      check_state("R3 bad");
      send_pkt(3, 1'b1, 1'b0);
      check_state("R3 next good");
      read_n(3, "R3");

      // R4 two packets held, clear exposes second
      send_pkt(7, 1'b1, 1'b0);
      check_state("R4 two stored");
      pulse(1'b0, 1'b1, 1'b0);
      check_state("R6 serviced ignored");
      pulse(1'b1, 1'b0, 1'b0);
      check_state("R4 second ready");
      read_n(7, "R4");

      // R9 flush with two stored
      send_pkt(2, 1'b1, 1'b0);
      check_state("R9 two stored");
      pulse(1'b0, 1'b0, 1'b1);
      check_state("R9 flush oldest");
      read_n(2, "R9");

      // R12 release and packet end in the same cycle
      set_cfg(16, 1'b0, 1'b0);
      send_pkt(4, 1'b1, 1'b0);
      send_pkt(6, 1'b1, 1'b1);
      check_state("R12 overlap");
      read_n(6, "R12");

      // R7 control mode
      set_cfg(16, 1'b1, 1'b1);
      send_pkt(16, 1'b1, 1'b0);
      read_n(16, "R7 no auto");
      check_state("R7 auto inactive");
      pulse(1'b1, 1'b0, 1'b0);
      check_state("R7 clr ignored");
      pulse(1'b0, 1'b1, 1'b0);
      check_state("R7 serviced");

      // R8 auto-clear
      set_cfg(8, 1'b1, 1'b0);
      send_pkt(8, 1'b1, 1'b0);
      read_n(8, "R8");
      check_state("R8 auto released");
      send_pkt(3, 1'b1, 1'b0);
      read_n(8, "R8 short");
      check_state("R8 short kept");

      // R11 oversize packet
      set_cfg(8, 1'b0, 1'b0);
      send_pkt(12, 1'b1, 1'b0);
      check_state("R11 clipped");
      read_n(8, "R11");

      // R5 single buffering, packet opened while full
      set_cfg(40, 1'b0, 1'b0);
      send_pkt(10, 1'b1, 1'b0);
      check_state("R5 full");
      send_pkt(5, 1'b1, 1'b0);
      check_state("R5 dropped");
      rx_valid = 1'b1; rx_data = 8'hA5;
      @(negedge clk);
      rx_valid = 1'b0;
      pulse(1'b1, 1'b0, 1'b0);
      rx_valid = 1'b1; rx_data = 8'h5A;
      @(negedge clk);
      rx_valid = 1'b0; rx_good = 1'b1;
      @(negedge clk);
      rx_good = 1'b0;
      check_state("R5 late slot");

      // random mix
      for (int blk = 0; blk < 12; blk++) begin
         int mp;
         mp = ($urandom_range(1, 0) == 1) ? int'($urandom_range(DEPTH / 2, 1))
                                          : int'($urandom_range(DEPTH, DEPTH / 2 + 1));
         set_cfg(mp, 1'($urandom), 1'($urandom));
         for (int op = 0; op < 30; op++) begin
            case ($urandom_range(5, 0))
               0, 1: send_pkt(int'($urandom_range(mmaxp + 2, 0)), 1'b1, 1'b0);
               2: send_pkt(int'($urandom_range(mmaxp, 0)), 1'b0, 1'b0);
               3: read_n(int'($urandom_range(mmaxp + 1, 1)), "R2 random");
               4: pulse(1'($urandom), 1'($urandom), 1'b0);
               default: pulse(1'b0, 1'b0, 1'($urandom));
            endcase
            check_state("R4 random");
         end
      end
      finish_run();
   end
endmodule